// File: doc/BRIEF.md
# Hardware Return Address Stack

This block stores return addresses for a processor core. It is separate from program memory and from data memory. When the core executes a call, or when it acknowledges an interrupt, it raises the push strobe with the current program counter value, and the block saves that value on top of the stack. When a return of any kind executes, the core raises the pop strobe and loads the program counter from the top-of-stack output in the same cycle. The stack holds 31 entries of 21 bits.

Software reaches the stack through a small byte-wide register bus. Through it, software can read and write the stack pointer and the two sticky error flags. It can read and edit the top entry as three bytes. It can also push or pop through a command register. An empty stack has a pointer of 0. Entry n sits at pointer value n.

Top module: `hw_ret_stack`

## Requirements
- R1: After reset the pointer is 0, both flags are clear, the pointer register reads 0x00 and `top_addr` is 0.
- R2: A push with the pointer below 31 first increments the pointer and then stores `push_addr` at the new pointer. From the next cycle, `top_addr` shows that value.
- R3: A pop with the pointer above 0 presents the top entry on `top_addr` in the same cycle and decrements the pointer at the clock edge. Entries therefore come back in last-in first-out order.
- R4: A push with the pointer at 31 leaves the pointer and every entry unchanged, and sets the overflow flag (pointer register bit 7).
- R5: A pop with the pointer at 0 presents 0 on `top_addr`, leaves the pointer at 0, and sets the underflow flag (pointer register bit 6).
- R6: Both flags are sticky through later pushes and pops. They change only when the pointer register is written.
- R7: The pointer register is at address 3 and reads {overflow, underflow, 0, pointer[4:0]}. A write loads the pointer from bits 4:0 and loads the two flags from bits 7 and 6. After the write, `top_addr` shows the entry at the new pointer.
- R8: Addresses 0, 1 and 2 read bits 7:0, bits 15:8 and bits 20:16 of the top entry. Address 2 pads the upper bits with zeros.
- R9: A write to address 0, 1 or 2 replaces only that byte of the entry at the current pointer. Entries below it are untouched. When the pointer is 0, such a write is ignored.
- R10: A write to the command register at address 4 acts as follows. With bit 0 set, it pushes `push_addr`. With only bit 1 set, it pops. The push, pop, overflow and underflow rules are the same as for the hardware strobes.
- R11: When `push` and `pop` are high together, only the push happens. When either strobe is high, a register write in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push | input | 1 | Call or interrupt push strobe |
| push_addr | input | 21 | Address to push |
| pop | input | 1 | Return pop strobe |
| top_addr | output | 21 | Top entry, or 0 when empty |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |

## Verification
The bench fills the stack to exactly 31 entries and then pushes again. A design with an off-by-one full test would either overwrite or lose an entry, and the top value or the pointer read would give it away. It pops an empty stack and expects a zero return. A design that wraps the pointer would show 31 instead and hand back stale data. It checks that the flags survive later traffic and that a byte write at pointer 0 leaves the stack alone. It also collides the two strobes, and collides a strobe with a register write. A wrong priority shows up as a pointer that did not move, or as one that took the software value.

// File: rtl/hw_ret_stack.sv
module hw_ret_stack #(
  parameter int DEPTH = 31,
  parameter int AW    = 21,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic [AW-1:0] top_addr,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata
);
  localparam logic [PW-1:0] FULLP = PW'(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr;
  logic          ovf, unf;

  wire hw_act   = push | pop;
  wire sw_we    = reg_we & ~hw_act;
  wire cmd_push = sw_we & (reg_addr == 3'd4) & reg_wdata[0];
  wire cmd_pop  = sw_we & (reg_addr == 3'd4) & reg_wdata[1] & ~reg_wdata[0];
  wire do_push  = push | cmd_push;
  wire do_pop   = (pop & ~push) | cmd_pop;
  wire ptr_we   = sw_we & (reg_addr == 3'd3);
  wire empty    = (ptr == '0);
  wire full     = (ptr == FULLP);
  wire tos_we   = sw_we & (reg_addr < 3'd3) & ~empty;
  wire [PW-1:0] tix = ptr - 1'b1;

  assign top_addr = empty ? '0 : mem[tix];

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = top_addr[7:0];
      3'd1:    reg_rdata = top_addr[15:8];
      3'd2:    reg_rdata = 8'(top_addr[AW-1:16]);
      3'd3:    reg_rdata = {ovf, unf, {(6-PW){1'b0}}, ptr};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (do_push && !full)
      mem[ptr] <= push_addr;
    else if (tos_we) begin
      case (reg_addr)
        3'd0:    mem[tix][7:0]     <= reg_wdata;
        3'd1:    mem[tix][15:8]    <= reg_wdata;
        default: mem[tix][AW-1:16] <= reg_wdata[AW-17:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else if (do_push) begin
      if (full) ovf <= 1'b1;
      else      ptr <= ptr + 1'b1;
    end else if (do_pop) begin
      if (empty) unf <= 1'b1;
      else       ptr <= tix;
    end else if (ptr_we) begin
      ptr <= (reg_wdata[PW-1:0] > FULLP) ? FULLP : reg_wdata[PW-1:0];
      ovf <= reg_wdata[7];
      unf <= reg_wdata[6];
    end
  end
endmodule

// File: rtl/hw_ret_stack_chk.sv
module hw_ret_stack_chk #(
  parameter int DEPTH = 31,
  parameter int AW    = 21,
  parameter int PW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push,
  input logic          pop,
  input logic [AW-1:0] push_addr,
  input logic [AW-1:0] top_addr,
  input logic [PW-1:0] ptr,
  input logic          ovf,
  input logic          unf,
  input logic          reg_we,
  input logic [2:0]    reg_addr
);
  a_r2_push_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (push && ptr != PW'(DEPTH)) |=> (ptr == $past(ptr) + 1'b1 && top_addr == $past(push_addr)));

  a_r3_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && ptr != '0) |=> (ptr == $past(ptr) - 1'b1));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && ptr == PW'(DEPTH)) |=> (ovf && ptr == PW'(DEPTH) && $stable(top_addr)));

  a_r5_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && ptr == '0) |-> (top_addr == '0));

  a_r5_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && ptr == '0) |=> (unf && ptr == '0));

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(reg_we && reg_addr == 3'd3)) |=> ovf);

  a_r6_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (unf && !(reg_we && reg_addr == 3'd3)) |=> unf);
endmodule

bind hw_ret_stack hw_ret_stack_chk #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .push_addr(push_addr),
  .top_addr(top_addr), .ptr(ptr), .ovf(ovf), .unf(unf),
  .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/tb_hw_ret_stack.sv
module tb_hw_ret_stack;
  logic clk = 0, rst_n = 0;
  logic push = 0, pop = 0, reg_we = 0;
  logic [20:0] push_addr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [20:0] top_addr;
  logic [7:0] reg_rdata;

  int total = 0, bad = 0;
  logic [20:0] m [32];
  int mp = 0;
  bit movf = 0, munf = 0;

  always #10 clk = ~clk;

  hw_ret_stack dut (.*);

  function automatic logic [20:0] mtop();
    return (mp == 0) ? 21'd0 : m[mp];
  endfunction

  function automatic void mpush(logic [20:0] a);
    if (mp == 31) movf = 1;
    else begin mp++; m[mp] = a; end
  endfunction

  function automatic logic [20:0] mpop();
    logic [20:0] v;
    if (mp == 0) begin munf = 1; return 21'd0; end
    v = m[mp]; mp--;
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic chk_state(string tag);
    logic [7:0] d;
    rd(3'd3, d);
    chk({tag, " ptr reg"}, d, {movf, munf, 1'b0, 5'(mp)});
    chk({tag, " top"}, top_addr, mtop());
  endtask

  task automatic hpush(logic [20:0] a);
    @(negedge clk); push = 1; push_addr = a;
    @(negedge clk); push = 0;
    mpush(a);
  endtask

  task automatic hpop(string tag);
    logic [20:0] e;
    @(negedge clk); pop = 1; #1;
    e = mpop();
    chk({tag, " pop value"}, top_addr, e);
    @(negedge clk); pop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_state("R1");

    hpush(21'h1ABCDE); hpush(21'h012345); hpush(21'h0F00F1);
    chk_state("R2");

    rd(3'd0, d); chk("R8 low", d, mtop() & 8'hFF);
    rd(3'd1, d); chk("R8 high", d, (mtop() >> 8) & 8'hFF);
    rd(3'd2, d); chk("R8 upper", d, mtop() >> 16);

    hpop("R3"); hpop("R3");
    chk_state("R3");
    hpop("R3");
    hpop("R5");
    chk_state("R5");

    hpush(21'h000777); hpop("R6"); hpush(21'h000888);
    chk_state("R6 kept");
    wr(3'd3, 8'(mp)); munf = 0;
    chk_state("R6 cleared");

    for (int i = 0; i < 32; i++) hpush(21'(21'h100 + i * 3));
    chk_state("R4");
    hpush(21'h1FFFFF);
    chk_state("R4 again");

    wr(3'd3, 8'd5); mp = 5; movf = 0; munf = 0;
    chk_state("R7");

    wr(3'd0, 8'hA5); m[5][7:0] = 8'hA5;
    wr(3'd2, 8'h1F); m[5][20:16] = 5'h1F;
    chk_state("R9");
    hpop("R9"); hpop("R9");
    chk_state("R9 below");
    wr(3'd3, 8'd0); mp = 0;
    wr(3'd0, 8'h33);
    chk_state("R9 empty");
    wr(3'd3, 8'd1); mp = 1;
    chk_state("R9 unchanged");

    push_addr = 21'h0ACE01;
    wr(3'd4, 8'h01); mpush(21'h0ACE01);
    chk_state("R10 push");
    wr(3'd4, 8'h02); void'(mpop());
    chk_state("R10 pop");

    @(negedge clk); push = 1; pop = 1; push_addr = 21'h0BEEF0;
    @(negedge clk); push = 0; pop = 0; mpush(21'h0BEEF0);
    chk_state("R11 both");
    @(negedge clk); push = 1; push_addr = 21'h0CAFE0;
    reg_we = 1; reg_addr = 3'd3; reg_wdata = 8'd0;
    @(negedge clk); push = 0; reg_we = 0; mpush(21'h0CAFE0);
    chk_state("R11 drop");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule